// File: doc/BRIEF.md
# Link-side acknowledge transmit controller

This block sits on the link side of an 8-bit parallel link-to-PHY interface for a serial bus node. The PHY drives the 2-bit control lines and 8-bit data lines when it owns them. The block watches those lines and reports when each received packet begins. It also reports null packets. A null packet is a receive that shows only the all-ones data-on indication and then goes idle, with no speed code and no data. The PHY sends one when the link takes the bus and releases it without sending, or when the packet speed is too high for the receiver. The link treats it as an error indication. When a packet arrives, the block passes the data bytes on in packet-format bit order.

When the surrounding link logic decides that a received primary packet needs an acknowledge, it pulses `ack_req_i` with a 4-bit acknowledge code. The block then sends an immediate-priority bus request serially on `lreq_o` and waits for the grant. After the grant it leaves the lines alone for one idle turnaround cycle. It then drives the acknowledge byte with the transmit code, drives idle for one cycle, and hands the lines back to the PHY. If the grant does not arrive within `timeout_i` cycles, or a receive starts instead, the acknowledge is dropped and `ack_err_o` pulses. The block also supplies the source-ID field for outgoing requests and flags a zero node ID, because a remote node drops responses to a request whose source ID is zero.

Control-line values on `ctl_i`/`ctl_o`: index 0 is the bit that is written first. The four values are idle `2'b00`, receive `2'b01` (bit 0 = 1, bit 1 = 0), transmit `2'b10` (bit 0 = 0, bit 1 = 1) and grant `2'b11`.

The acknowledge state machine has seven states:
- IDLE: accepts `ack_req_i`.
- REQ: shifts out the request.
- WAIT: waits for the grant; it goes to TURN on a grant, or to ABORT on a receive or on timeout.
- TURN: the idle turnaround cycle, with the lines not driven.
- XMIT: drives the acknowledge byte.
- REL: drives idle and pulses done; it always returns to IDLE.
- ABORT: pulses the error flag; it always returns to IDLE.

Top module: `lnk_ack_ctrl`

## Requirements
- R1: After reset, `bus_oe_o`, `lreq_o`, `pkt_start_o`, `null_pkt_o`, `rx_vld_o`, `ack_done_o` and `ack_err_o` are all 0.
- R2: An `ack_req_i` pulse sampled in IDLE makes `lreq_o` carry the 7-bit frame 1,0,1,1,0,1,0 over the next seven cycles. This is a start bit, then the immediate request type 011, then speed 010 (400 Mb/s). After the frame `lreq_o` stays 0.
- R3: A grant (`ctl_i`=11) seen in WAIT is followed by one cycle with `bus_oe_o`=0. Then comes one cycle with `bus_oe_o`=1 and `ctl_o`=10 carrying the acknowledge byte. Then comes one cycle with `bus_oe_o`=1, `ctl_o`=00 and `ack_done_o`=1. After that `bus_oe_o` returns to 0.
- R4: The acknowledge byte is {code[3:0], ~code[3:0]}, and it is driven on `d_o` bit-reversed. Code 1 gives 0x1E, driven as 0x78. Code 2 gives 0x2D, driven as 0xB4.
- R5: With no grant, WAIT lasts `timeout_i` cycles (a value of 0 acts as 1). Then `ack_err_o` is 1 for one cycle, the lines are never driven, and the block returns to IDLE.
- R6: A receive code on `ctl_i` during WAIT abandons the acknowledge: `ack_err_o` pulses in the next cycle and the lines are never driven.
- R7: In a receive, the first data byte other than 0xFF that follows at least one 0xFF byte is the speed code. The cycle after it is sampled, `pkt_start_o` pulses for one cycle.
- R8: A receive whose bytes are all 0xFF and that is followed directly by idle gives a one-cycle `null_pkt_o` pulse in the cycle after the idle. `pkt_start_o` does not pulse for it.
- R9: Each receive byte after the speed code appears on `rx_byte_o` bit-reversed, with `rx_vld_o`=1, one cycle after it is sampled.
- R10: `src_id_o` equals `node_id_i`. `src_id_bad_o` is 1 exactly when `node_id_i` is zero.
- R11: An `ack_req_i` pulse outside IDLE is ignored. The acknowledge in progress still carries the code that was latched when it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| node_id_i | input | NW | Configured node ID |
| timeout_i | input | TW | Grant wait limit in cycles |
| ack_req_i | input | 1 | Request to acknowledge, one-cycle pulse |
| ack_code_i | input | 4 | Acknowledge code, latched with the request |
| ctl_i | input | 2 | Control lines as driven by the PHY |
| d_i | input | 8 | Data lines as driven by the PHY |
| ctl_o | output | 2 | Control value driven by the link |
| d_o | output | 8 | Data value driven by the link |
| bus_oe_o | output | 1 | Enable that tri-states the link's control and data lines |
| lreq_o | output | 1 | Serial bus request |
| pkt_start_o | output | 1 | Received packet start pulse |
| null_pkt_o | output | 1 | Null packet error pulse |
| rx_vld_o | output | 1 | Received byte valid |
| rx_byte_o | output | 8 | Received byte in packet-format bit order |
| ack_done_o | output | 1 | Acknowledge sent, release cycle |
| ack_err_o | output | 1 | Acknowledge abandoned |
| src_id_o | output | NW | Source ID for outgoing requests |
| src_id_bad_o | output | 1 | Node ID is zero |

## Verification
Every result of this block appears at a fixed cycle offset from the edge that samples its cause:
- The first request bit is due one cycle after `ack_req_i` is sampled.
- The turnaround cycle comes one cycle after the grant is sampled, the acknowledge byte two cycles after, and the release three cycles after.
- The abort flag comes one cycle after the receive code or after the last wait cycle.
- The receive pulses and bytes come one cycle after the line value that causes them.

Each directed task drives inputs on the falling edge, steps one falling edge per cycle, and compares the outputs at exactly those offsets. A result that arrives a cycle early or late is therefore reported as a miscompare.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
    localparam logic [1:0] CTL_IDLE = 2'b00;
    localparam logic [1:0] CTL_RX   = 2'b01;
    localparam logic [1:0] CTL_TX   = 2'b10;
    localparam logic [1:0] CTL_GNT  = 2'b11;

    localparam int         BYTE_W   = 8;
    localparam int         CODE_W   = 4;
    localparam int         REQ_LEN  = 7;
    // start bit, immediate type 011, speed 010
    localparam logic [REQ_LEN-1:0] REQ_FRAME = 7'b1_011_010;

    typedef enum logic [2:0] {
        S_IDLE, S_REQ, S_WAIT, S_TURN, S_XMIT, S_REL, S_ABORT
    } ack_state_t;

    function automatic logic [BYTE_W-1:0] bit_rev(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = b[BYTE_W-1-i];
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] ack_byte(input logic [CODE_W-1:0] c);
        return {c, ~c};
    endfunction
endpackage

// File: rtl/lnk_rx_mon.sv
module lnk_rx_mon
    import lnk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        ctl_i,
    input  logic [BYTE_W-1:0] d_i,
    output logic              pkt_start_o,
    output logic              null_pkt_o,
    output logic              rx_vld_o,
    output logic [BYTE_W-1:0] rx_byte_o
);
    logic on_q;    // data-on seen, no speed code yet
    logic data_q;  // speed code seen, payload follows

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_q        <= 1'b0;
            data_q      <= 1'b0;
            pkt_start_o <= 1'b0;
            null_pkt_o  <= 1'b0;
            rx_vld_o    <= 1'b0;
            rx_byte_o   <= '0;
        end else begin
            pkt_start_o <= 1'b0;
            null_pkt_o  <= 1'b0;
            rx_vld_o    <= 1'b0;
            if (ctl_i == CTL_RX) begin
                if (data_q) begin
                    rx_vld_o  <= 1'b1;
                    rx_byte_o <= bit_rev(d_i);
                end else if (d_i == '1) begin
                    on_q <= 1'b1;
                end else if (on_q) begin
                    pkt_start_o <= 1'b1;
                    data_q      <= 1'b1;
                    on_q        <= 1'b0;
                end
            end else begin
                if (on_q && ctl_i == CTL_IDLE) null_pkt_o <= 1'b1;
                on_q   <= 1'b0;
                data_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/lnk_req_ser.sv
module lnk_req_ser
    import lnk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic lreq_o,
    output logic last_o
);
    localparam int CW = $clog2(REQ_LEN);

    logic [REQ_LEN-1:0] sh_q;
    logic [CW-1:0]      cnt_q;
    logic               act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
            act_q <= 1'b0;
        end else if (load_i) begin
            sh_q  <= REQ_FRAME;
            cnt_q <= CW'(REQ_LEN - 1);
            act_q <= 1'b1;
        end else if (act_q) begin
            sh_q  <= sh_q << 1;
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == '0) act_q <= 1'b0;
        end
    end

    assign lreq_o = act_q & sh_q[REQ_LEN-1];
    assign last_o = act_q & (cnt_q == '0);
endmodule

// File: rtl/lnk_ack_fsm.sv
module lnk_ack_fsm
    import lnk_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_req_i,
    input  logic [CODE_W-1:0] ack_code_i,
    input  logic [1:0]        ctl_i,
    input  logic [TW-1:0]     timeout_i,
    input  logic              req_last_i,
    output logic              req_load_o,
    output logic [1:0]        ctl_o,
    output logic [BYTE_W-1:0] d_o,
    output logic              bus_oe_o,
    output logic              ack_done_o,
    output logic              ack_err_o
);
    ack_state_t        st_q, st_d;
    logic [CODE_W-1:0] code_q;
    logic [TW-1:0]     wcnt_q;
    logic              wait_over;

    assign wait_over = ({1'b0, wcnt_q} + 1'b1) >= {1'b0, timeout_i};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            wcnt_q <= '0;
        end else begin
            if (st_q == S_IDLE && ack_req_i) code_q <= ack_code_i;
            if (st_q == S_WAIT) wcnt_q <= wcnt_q + 1'b1;
            else                wcnt_q <= '0;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (ack_req_i) st_d = S_REQ;
            S_REQ:   if (req_last_i) st_d = S_WAIT;
            S_WAIT: begin
                if (ctl_i == CTL_GNT)     st_d = S_TURN;
                else if (ctl_i == CTL_RX) st_d = S_ABORT;
                else if (wait_over)       st_d = S_ABORT;
            end
            S_TURN:  st_d = S_XMIT;
            S_XMIT:  st_d = S_REL;
            S_REL:   st_d = S_IDLE;
            S_ABORT: st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    always_comb begin
        req_load_o = 1'b0;
        ctl_o      = CTL_IDLE;
        d_o        = '0;
        bus_oe_o   = 1'b0;
        ack_done_o = 1'b0;
        ack_err_o  = 1'b0;
        unique case (st_q)
            S_IDLE:  req_load_o = ack_req_i;
            S_XMIT: begin
                bus_oe_o = 1'b1;
                ctl_o    = CTL_TX;
                d_o      = bit_rev(ack_byte(code_q));
            end
            S_REL: begin
                bus_oe_o   = 1'b1;
                ack_done_o = 1'b1;
            end
            S_ABORT: ack_err_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/lnk_ack_ctrl.sv
module lnk_ack_ctrl
    import lnk_pkg::*;
#(
    parameter int NW = 16,
    parameter int TW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NW-1:0]     node_id_i,
    input  logic [TW-1:0]     timeout_i,
    input  logic              ack_req_i,
    input  logic [3:0]        ack_code_i,
    input  logic [1:0]        ctl_i,
    input  logic [7:0]        d_i,
    output logic [1:0]        ctl_o,
    output logic [7:0]        d_o,
    output logic              bus_oe_o,
    output logic              lreq_o,
    output logic              pkt_start_o,
    output logic              null_pkt_o,
    output logic              rx_vld_o,
    output logic [7:0]        rx_byte_o,
    output logic              ack_done_o,
    output logic              ack_err_o,
    output logic [NW-1:0]     src_id_o,
    output logic              src_id_bad_o
);
    logic req_load, req_last;

    lnk_rx_mon u_rx (
        .clk(clk), .rst_n(rst_n), .ctl_i(ctl_i), .d_i(d_i),
        .pkt_start_o(pkt_start_o), .null_pkt_o(null_pkt_o),
        .rx_vld_o(rx_vld_o), .rx_byte_o(rx_byte_o)
    );

    lnk_req_ser u_req (
        .clk(clk), .rst_n(rst_n), .load_i(req_load),
        .lreq_o(lreq_o), .last_o(req_last)
    );

    lnk_ack_fsm #(.TW(TW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ack_req_i(ack_req_i),
        .ack_code_i(ack_code_i), .ctl_i(ctl_i), .timeout_i(timeout_i),
        .req_last_i(req_last), .req_load_o(req_load), .ctl_o(ctl_o),
        .d_o(d_o), .bus_oe_o(bus_oe_o), .ack_done_o(ack_done_o),
        .ack_err_o(ack_err_o)
    );

    assign src_id_o     = node_id_i;
    assign src_id_bad_o = (node_id_i == '0);
endmodule

// File: rtl/lnk_ack_ctrl_chk.sv
module lnk_ack_ctrl_chk
    import lnk_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] ctl_i,
    input logic [1:0] ctl_o,
    input logic [7:0] d_o,
    input logic       bus_oe_o,
    input logic       lreq_o,
    input logic       pkt_start_o,
    input logic       null_pkt_o,
    input logic       ack_done_o,
    input logic       ack_err_o
);
    logic [7:0] fmt_byte;
    assign fmt_byte = bit_rev(d_o);

    // R3: link drive starts only after grant then one idle turnaround
    p_drive_after_turn_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe_o) |-> ($past(ctl_i) == CTL_IDLE && $past(ctl_i, 2) == CTL_GNT));

    // R4: parity nibble is the inverse of the code nibble
    p_ack_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o && ctl_o == CTL_TX) |-> (fmt_byte[3:0] == ~fmt_byte[7:4]));

    // R3: release cycle directly follows the transmit cycle
    p_release_after_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_done_o |-> ($past(bus_oe_o) && $past(ctl_o) == CTL_TX));

    // R3: the line is free again after the release
    p_bus_freed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_done_o |=> !bus_oe_o);

    // R5: an abandoned acknowledge never drives the lines
    p_no_drive_on_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err_o |-> (!bus_oe_o && !ack_done_o));

    // R2: no request bits while the link drives the lines
    p_lreq_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> !lreq_o);

    // R8: a null packet is never also a packet start
    p_null_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(null_pkt_o && pkt_start_o));
endmodule

bind lnk_ack_ctrl lnk_ack_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl_i), .ctl_o(ctl_o), .d_o(d_o),
    .bus_oe_o(bus_oe_o), .lreq_o(lreq_o), .pkt_start_o(pkt_start_o),
    .null_pkt_o(null_pkt_o), .ack_done_o(ack_done_o), .ack_err_o(ack_err_o)
);

// File: tb/lnk_ack_ctrl_tb_top.sv
module lnk_ack_ctrl_tb_top;
    localparam int NW = 16;
    localparam int TW = 8;
    localparam logic [6:0] EXP_FRAME = 7'b1011010;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NW-1:0] node_id_i = '0;
    logic [TW-1:0] timeout_i = 8'd20;
    logic          ack_req_i = 1'b0;
    logic [3:0]    ack_code_i = '0;
    logic [1:0]    ctl_i = 2'b00;
    logic [7:0]    d_i = '0;
    logic [1:0]    ctl_o;
    logic [7:0]    d_o;
    logic          bus_oe_o, lreq_o, pkt_start_o, null_pkt_o, rx_vld_o;
    logic [7:0]    rx_byte_o;
    logic          ack_done_o, ack_err_o;
    logic [NW-1:0] src_id_o;
    logic          src_id_bad_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    lnk_ack_ctrl #(.NW(NW), .TW(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .node_id_i(node_id_i), .timeout_i(timeout_i),
        .ack_req_i(ack_req_i), .ack_code_i(ack_code_i), .ctl_i(ctl_i), .d_i(d_i),
        .ctl_o(ctl_o), .d_o(d_o), .bus_oe_o(bus_oe_o), .lreq_o(lreq_o),
        .pkt_start_o(pkt_start_o), .null_pkt_o(null_pkt_o), .rx_vld_o(rx_vld_o),
        .rx_byte_o(rx_byte_o), .ack_done_o(ack_done_o), .ack_err_o(ack_err_o),
        .src_id_o(src_id_o), .src_id_bad_o(src_id_bad_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 oe", bus_oe_o, 0);
        check("R1 lreq", lreq_o, 0);
        check("R1 rx flags", {pkt_start_o, null_pkt_o, rx_vld_o}, 0);
        check("R1 ack flags", {ack_done_o, ack_err_o}, 0);
    endtask

    // sends request frame; optional extra ack_req pulse mid-frame (R11)
    task automatic send_req(input logic [3:0] code, input bit poke);
        @(negedge clk); ack_req_i = 1'b1; ack_code_i = code;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            ack_req_i = (poke && i == 3);
            if (poke && i == 3) ack_code_i = 4'hF;
            check("R2 frame bit", lreq_o, EXP_FRAME[6-i]);
        end
        ack_req_i = 1'b0;
    endtask

    task automatic t_ack(input logic [3:0] code, input logic [7:0] line, input bit poke);
        send_req(code, poke);
        @(negedge clk); ctl_i = 2'b11; d_i = 8'hAF;
        check("R2 lreq low", lreq_o, 0);
        check("R3 no drive in wait", bus_oe_o, 0);
        @(negedge clk); ctl_i = 2'b00; d_i = 8'h00;
        check("R3 turnaround undriven", bus_oe_o, 0);
        @(negedge clk);
        check("R3 tx drive", {bus_oe_o, ctl_o}, {1'b1, 2'b10});
        check(poke ? "R11 code kept" : "R4 ack byte", d_o, line);
        @(negedge clk);
        check("R3 release idle", {bus_oe_o, ctl_o, ack_done_o}, {1'b1, 2'b00, 1'b1});
        @(negedge clk);
        check("R3 bus freed", {bus_oe_o, ack_done_o, ack_err_o}, 0);
    endtask

    task automatic t_timeout();
        timeout_i = 8'd4;
        send_req(4'h1, 1'b0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R5 waiting", {ack_err_o, bus_oe_o}, 0);
        end
        @(negedge clk);
        check("R5 timeout err", {ack_err_o, bus_oe_o}, {1'b1, 1'b0});
        @(negedge clk);
        check("R5 err one cycle", {ack_err_o, bus_oe_o}, 0);
        timeout_i = 8'd20;
    endtask

    task automatic t_rx_abort();
        send_req(4'h1, 1'b0);
        @(negedge clk); ctl_i = 2'b01; d_i = 8'hFF;
        @(negedge clk); ctl_i = 2'b00; d_i = 8'h00;
        check("R6 rx abort err", {ack_err_o, bus_oe_o}, {1'b1, 1'b0});
        @(negedge clk);
        check("R6 no drive after abort", {ack_err_o, bus_oe_o, ack_done_o}, 0);
        @(negedge clk);
        check("R6 stays undriven", bus_oe_o, 0);
    endtask

    task automatic t_rx_packet();
        @(negedge clk); ctl_i = 2'b01; d_i = 8'hFF;
        @(negedge clk); d_i = 8'h02;
        check("R7 no start on data-on", pkt_start_o, 0);
        @(negedge clk); d_i = 8'h78;
        check("R7 pkt start", pkt_start_o, 1);
        @(negedge clk); d_i = 8'hC0;
        check("R9 byte reversed", {rx_vld_o, rx_byte_o}, {1'b1, 8'h1E});
        check("R7 start one cycle", pkt_start_o, 0);
        @(negedge clk); ctl_i = 2'b00; d_i = 8'h00;
        check("R9 second byte", {rx_vld_o, rx_byte_o}, {1'b1, 8'h03});
        @(negedge clk);
        check("R8 no null after real packet", {null_pkt_o, rx_vld_o}, 0);
    endtask

    task automatic t_null();
        @(negedge clk); ctl_i = 2'b01; d_i = 8'hFF;
        @(negedge clk);
        @(negedge clk); ctl_i = 2'b00; d_i = 8'h00;
        check("R8 no early flag", {null_pkt_o, pkt_start_o}, 0);
        @(negedge clk);
        check("R8 null pulse", {null_pkt_o, pkt_start_o}, {1'b1, 1'b0});
        @(negedge clk);
        check("R8 null one cycle", null_pkt_o, 0);
    endtask

    task automatic t_src_id();
        node_id_i = 16'h0000; #1;
        check("R10 zero id flagged", {src_id_bad_o, src_id_o}, {1'b1, 16'h0000});
        node_id_i = 16'h03C5; #1;
        check("R10 id passed", {src_id_bad_o, src_id_o}, {1'b0, 16'h03C5});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_src_id();
        t_ack(4'h1, 8'h78, 1'b0);
        t_ack(4'h2, 8'hB4, 1'b0);
        t_ack(4'h1, 8'h78, 1'b1);
        t_timeout();
        t_rx_abort();
        t_rx_packet();
        t_null();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule